// File: doc/BRIEF.md
# I2C Byte-Step Master

This block is an I2C bus master that software drives one bus event at a time. Each event is a START or repeated START, a STOP, one transmitted byte with its acknowledge slot, or one received byte with the master's acknowledge. Three byte-wide registers control it: a data register, a control register and a read-only status register. A fourth register address triggers a soft reset. When an event other than STOP completes, the block sets a completion flag and loads a one-byte status code that names the bus state it has reached. Software reads that code and then writes the control register again to start the next event.

The bus lines are open-drain. For each of SCL and SDA the block has a drive-low output and a sampled input, and the line is pulled high outside the block. The master holds SCL low between events so that the bus stays owned. A 10-bit address is sent by software as two address bytes. The block does not act as a slave, does not wait on a slave that stretches SCL, and reports a failed START only as an error code.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0xF8, the control register reads 0x00, irq is low, and both drive-low outputs are low.
- R2: Writing control with core enable (0x40) and START (0x20) set and the completion flag (0x08) clear, while the bus is not owned, produces a START (SDA falls while SCL is high). The completion flag is then set and status reads 0x08.
- R3: The same START request made while the bus is owned produces a repeated START and status 0x10.
- R4: A byte written after a START is an address byte: bits 7..1 are the 7-bit address and bit 0 is the R/W bit, with 1 meaning read. Status afterwards is 0x18 (write, ACK), 0x20 (write, NAK), 0x40 (read, ACK) or 0x48 (read, NAK).
- R5: Any other transmitted byte goes out MSB first. Status afterwards is 0x28 on ACK and 0x30 on NAK.
- R6: After an address with read ACK (0x40) or a received byte with ACK (0x50), an enable write starts a receive. The master drives ACK when control bit 0x04 was set in that write, giving status 0x50, and leaves SDA released otherwise, giving 0x58. The received byte goes into the data register.
- R7: A STOP request (0x40|0x10, flag clear) while the bus is owned produces SCL release followed by SDA release and returns status to 0xF8. It does not set the completion flag, and the next START reports 0x08.
- R8: Control readback is {irq enable, core enable, 0, 0, flag, ack, 0, 0}. irq is high exactly when irq enable and the flag are both set. A control write with the flag bit set starts nothing.
- R9: Writes to data and control while an event is in progress are ignored.
- R10: If SCL or SDA is low just before the START edge, status becomes 0x00, the flag is set and the bus is released.
- R11: A write to register address 3 aborts any event, releases both lines, clears the flag and sets status to 0xF8.
- R12: During a byte, the master changes SDA only while SCL is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 data, 1 control, 2 status, 3 soft reset |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| sclDrvLow | output | 1 | Pull SCL low when high |
| sdaDrvLow | output | 1 | Pull SDA low when high |

## Verification
Embedded properties check the following on every cycle. The flag stays clear while an event runs. SDA holds steady through each SCL-high half of a byte. An idle, unowned engine drives neither line. The flag rises only with the bus owned or with a bus-error code. A STOP is never accepted on a bus that is not owned. The status codes themselves can only be shown by bench scenarios, which run a behavioural slave on the open-drain wires. Those scenarios cover every 7-bit address in both directions, all 256 transmit values (the value 0xFF is NAKed), a run of received bytes with master ACK and NAK, repeated START, interrupt gating, writes made while busy, a bus held low at START, and a soft reset in the middle of a byte.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [1:0] {
    SDA_REL  = 2'd0,
    SDA_LOW  = 2'd1,
    SDA_DATA = 2'd2,
    SDA_ACK  = 2'd3
  } sdaSel_e;

  // control -> datapath
  typedef struct packed {
    logic    sclLow;
    sdaSel_e sdaSel;
    logic    inByte;
    logic    sampleBit;
    logic    byteDone;
    logic    startDone;
    logic    startErr;
    logic    stopDone;
    logic    busy;
  } engStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic start;
    logic stop;
    logic byteGo;
    logic owned;
    logic softRst;
  } engReq_t;

  localparam logic [7:0] ST_BUS_ERR  = 8'h00;
  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RESTART  = 8'h10;
  localparam logic [7:0] ST_AWR_ACK  = 8'h18;
  localparam logic [7:0] ST_AWR_NAK  = 8'h20;
  localparam logic [7:0] ST_TX_ACK   = 8'h28;
  localparam logic [7:0] ST_TX_NAK   = 8'h30;
  localparam logic [7:0] ST_ARD_ACK  = 8'h40;
  localparam logic [7:0] ST_ARD_NAK  = 8'h48;
  localparam logic [7:0] ST_RX_ACK   = 8'h50;
  localparam logic [7:0] ST_RX_NAK   = 8'h58;
  localparam logic [7:0] ST_IDLE     = 8'hF8;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_RST  = 2'd3;

endpackage

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl
  import i2cb_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  engReq_t    req,
  input  logic       sclIn,
  input  logic       sdaIn,
  output engStrobe_t stb
);

  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);
  localparam logic [3:0] ACK_BIT = 4'd8;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} engState_e;

  engState_e state;
  logic [1:0] phase;
  logic [3:0] bitIdx;
  logic hiHalf;
  logic [CW-1:0] cnt;
  logic tick;
  logic busFree;

  assign tick    = (cnt == CNT_LAST);
  assign busFree = sclIn && sdaIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= '0;
      bitIdx <= '0;
      hiHalf <= 1'b0;
      cnt    <= '0;
    end else if (req.softRst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      hiHalf <= 1'b0;
    end else begin
      cnt <= (state == S_IDLE || tick) ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          if (req.start) begin
            state <= S_START;
            phase <= req.owned ? 2'd0 : 2'd1;
          end else if (req.stop) begin
            state <= S_STOP;
            phase <= 2'd0;
          end else if (req.byteGo) begin
            state  <= S_BYTE;
            bitIdx <= '0;
            hiHalf <= 1'b0;
          end
        end
        S_START: if (tick) begin
          case (phase)
            2'd0: phase <= 2'd1;
            2'd1: if (busFree) phase <= 2'd2; else state <= S_IDLE;
            2'd2: phase <= 2'd3;
            default: state <= S_IDLE;
          endcase
        end
        S_BYTE: if (tick) begin
          if (!hiHalf) hiHalf <= 1'b1;
          else begin
            hiHalf <= 1'b0;
            if (bitIdx == ACK_BIT) state <= S_IDLE;
            else bitIdx <= bitIdx + 1'b1;
          end
        end
        default: if (tick) begin
          if (phase == 2'd2) state <= S_IDLE;
          else phase <= phase + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    stb = '0;
    stb.sdaSel = SDA_REL;
    stb.busy = (state != S_IDLE);
    case (state)
      S_IDLE: stb.sclLow = req.owned;
      S_START: begin
        stb.sclLow    = (phase == 2'd0) || (phase == 2'd3);
        stb.sdaSel    = (phase[1]) ? SDA_LOW : SDA_REL;
        stb.startErr  = (phase == 2'd1) && tick && !busFree;
        stb.startDone = (phase == 2'd3) && tick;
      end
      S_BYTE: begin
        stb.inByte    = 1'b1;
        stb.sclLow    = !hiHalf;
        stb.sdaSel    = (bitIdx == ACK_BIT) ? SDA_ACK : SDA_DATA;
        stb.sampleBit = hiHalf && tick && (bitIdx != ACK_BIT);
        stb.byteDone  = hiHalf && tick && (bitIdx == ACK_BIT);
      end
      default: begin
        stb.sclLow   = (phase == 2'd0);
        stb.sdaSel   = (phase == 2'd2) ? SDA_REL : SDA_LOW;
        stb.stopDone = (phase == 2'd2) && tick;
      end
    endcase
  end

  // R7: a STOP is only ever accepted on an owned bus
  p_stop_needs_owned_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && req.stop) |-> req.owned);

endmodule

// File: rtl/i2cb_datapath.sv
module i2cb_datapath
  import i2cb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  input  engStrobe_t stb,
  output engReq_t    req,
  input  logic       sdaIn,
  output logic       sclDrvLow,
  output logic       sdaDrvLow
);

  logic [7:0] dataReg, shiftReg, statusReg;
  logic ienReg, enReg, ackEn, flag, owned;
  logic rxMode, isAddr, addrRead;
  logic wrCtrl, wrData, goStep, rxNext, addrNext, sdaNext, ackSeen;
  logic [7:0] txStatus;

  assign wrCtrl   = regWr && (regAddr == RA_CTRL) && !stb.busy;
  assign wrData   = regWr && (regAddr == RA_DATA) && !stb.busy;
  assign goStep   = wrCtrl && regWdata[6] && !regWdata[3];
  assign rxNext   = (statusReg == ST_ARD_ACK) || (statusReg == ST_RX_ACK);
  assign addrNext = (statusReg == ST_START) || (statusReg == ST_RESTART);

  always_comb begin
    req.softRst = regWr && (regAddr == RA_RST);
    req.start   = goStep && regWdata[5];
    req.stop    = goStep && !regWdata[5] && regWdata[4] && owned;
    req.byteGo  = goStep && !regWdata[5] && !regWdata[4] && owned;
    req.owned   = owned;
  end

  always_comb begin
    case (stb.sdaSel)
      SDA_REL:  sdaNext = 1'b0;
      SDA_LOW:  sdaNext = 1'b1;
      SDA_DATA: sdaNext = !rxMode && !shiftReg[7];
      default:  sdaNext = rxMode && ackEn;
    endcase
  end

  assign ackSeen = !sdaIn;
  always_comb begin
    if (isAddr && addrRead) txStatus = ackSeen ? ST_ARD_ACK : ST_ARD_NAK;
    else if (isAddr)        txStatus = ackSeen ? ST_AWR_ACK : ST_AWR_NAK;
    else                    txStatus = ackSeen ? ST_TX_ACK  : ST_TX_NAK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg   <= '0;
      shiftReg  <= '0;
      statusReg <= ST_IDLE;
      ienReg    <= 1'b0;
      enReg     <= 1'b0;
      ackEn     <= 1'b0;
      flag      <= 1'b0;
      owned     <= 1'b0;
      rxMode    <= 1'b0;
      isAddr    <= 1'b0;
      addrRead  <= 1'b0;
      sdaDrvLow <= 1'b0;
    end else if (req.softRst) begin
      statusReg <= ST_IDLE;
      flag      <= 1'b0;
      owned     <= 1'b0;
      sdaDrvLow <= 1'b0;
    end else begin
      sdaDrvLow <= sdaNext;
      if (wrData) dataReg <= regWdata;
      if (wrCtrl) begin
        ienReg <= regWdata[7];
        enReg  <= regWdata[6];
        ackEn  <= regWdata[2];
        if (!regWdata[3]) flag <= 1'b0;
      end
      if (req.byteGo) begin
        shiftReg <= dataReg;
        rxMode   <= rxNext;
        isAddr   <= addrNext;
        addrRead <= dataReg[0];
      end
      if (stb.sampleBit) shiftReg <= {shiftReg[6:0], sdaIn};
      if (stb.startDone) begin
        statusReg <= owned ? ST_RESTART : ST_START;
        owned     <= 1'b1;
        flag      <= 1'b1;
      end
      if (stb.startErr) begin
        statusReg <= ST_BUS_ERR;
        owned     <= 1'b0;
        flag      <= 1'b1;
      end
      if (stb.byteDone) begin
        flag <= 1'b1;
        if (rxMode) begin
          statusReg <= ackEn ? ST_RX_ACK : ST_RX_NAK;
          dataReg   <= shiftReg;
        end else begin
          statusReg <= txStatus;
        end
      end
      if (stb.stopDone) begin
        statusReg <= ST_IDLE;
        owned     <= 1'b0;
      end
    end
  end

  assign sclDrvLow = stb.sclLow;
  assign irq = ienReg && flag;

  always_comb begin
    case (regAddr)
      RA_DATA: regRdata = dataReg;
      RA_CTRL: regRdata = {ienReg, enReg, 2'b00, flag, ackEn, 2'b00};
      RA_STAT: regRdata = statusReg;
      default: regRdata = 8'h00;
    endcase
  end

  p_flag_clear_while_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.busy |-> !flag);

  p_sda_steady_scl_high_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inByte && !stb.sclLow && $past(stb.inByte && !stb.sclLow)) |-> $stable(sdaDrvLow));

  p_idle_lines_released_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.busy && !owned) |-> (!sclDrvLow && !sdaDrvLow));

  p_flag_rise_owned_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> (owned || statusReg == ST_BUS_ERR));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDrvLow,
  output logic       sdaDrvLow
);

  engStrobe_t stb;
  engReq_t    req;

  i2cb_ctrl #(.HALF_CYC(HALF_CYC)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .req   (req),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .stb   (stb)
  );

  i2cb_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .irq       (irq),
    .stb       (stb),
    .req       (req),
    .sdaIn     (sdaIn),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow)
  );

endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = 2'd2;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic irq, sclDrvLow, sdaDrvLow;
  logic slvLow = 1'b0;
  logic slvForce = 1'b0;
  wire sclW = !sclDrvLow;
  wire sdaW = !(sdaDrvLow || slvLow || slvForce);

  int vectors = 0;
  int misses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .sclIn(sclW), .sdaIn(sdaW), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

  // behavioural slave on the open-drain wires
  bit prevScl = 1'b1, prevSda = 1'b1;
  bit active = 0, isAddrByte = 0, selected = 0, rdMode = 0, rdHalt = 0;
  bit masterAckSeen = 0;
  int bitPos = 0, rdIdx = 0;
  logic [7:0] shifter = 8'h00, txByte = 8'h00, lastWritten = 8'h00;

  function automatic logic [7:0] rdPattern(int k);
    return 8'h3C + 8'(k * 37);
  endfunction

  always @(sclW or sdaW) begin
    if (sclW && prevScl && prevSda && !sdaW) begin
      active = 1; bitPos = -1; isAddrByte = 1; selected = 0;
      rdMode = 0; rdHalt = 0; rdIdx = 0; slvLow = 0;
    end else if (sclW && prevScl && !prevSda && sdaW) begin
      active = 0; slvLow = 0;
    end else if (sclW && !prevScl) begin
      if (active) begin
        if (bitPos >= 0 && bitPos < 8) shifter = {shifter[6:0], sdaW};
        else if (bitPos == 8 && rdMode && !isAddrByte) begin
          masterAckSeen = !sdaW;
          if (sdaW) rdHalt = 1;
        end
      end
    end else if (!sclW && prevScl && active) begin
      bitPos++;
      if (bitPos == 8) begin
        slvLow = 0;
        if (isAddrByte) begin
          selected = (shifter[7:1] == SLV);
          rdMode = shifter[0];
          slvLow = selected;
        end else if (!rdMode) begin
          if (selected) lastWritten = shifter;
          slvLow = selected && (shifter != 8'hFF);
        end
      end else if (bitPos == 9) begin
        bitPos = 0; isAddrByte = 0; slvLow = 0;
        if (selected && rdMode && !rdHalt) begin
          txByte = rdPattern(rdIdx); rdIdx++;
          slvLow = !txByte[7];
        end
      end else if (bitPos >= 1 && bitPos <= 7 && selected && rdMode && !isAddrByte && !rdHalt)
        slvLow = !txByte[7 - bitPos];
    end
    prevScl = sclW; prevSda = sdaW;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitFlag(input string tag);
    logic [7:0] c;
    int n = 0;
    do begin
      @(negedge clk);
      rd(2'd1, c);
      n++;
    end while (!c[3] && n < 3000);
    if (!c[3]) chk({tag, " flag timeout"}, c, c | 8'h08);
  endtask

  task automatic doStart(input logic [7:0] expStat, input string tag);
    logic [7:0] s;
    wr(2'd1, 8'h60);
    waitFlag(tag);
    rd(2'd2, s);
    chk(tag, s, expStat);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic [7:0] expStat, input string tag);
    logic [7:0] s;
    wr(2'd0, b);
    wr(2'd1, 8'h40);
    waitFlag(tag);
    rd(2'd2, s);
    chk(tag, s, expStat);
  endtask

  task automatic recvByte(input bit ack, input logic [7:0] expData, input string tag);
    logic [7:0] s, d;
    wr(2'd1, ack ? 8'h44 : 8'h40);
    waitFlag(tag);
    rd(2'd2, s);
    chk({tag, " status"}, s, ack ? 8'h50 : 8'h58);
    rd(2'd0, d);
    chk({tag, " data"}, d, expData);
    chk({tag, " master ack"}, 8'(masterAckSeen), 8'(ack));
  endtask

  task automatic doStop(input string tag);
    logic [7:0] s, c;
    int n = 0;
    wr(2'd1, 8'h50);
    do begin
      @(negedge clk);
      rd(2'd2, s);
      n++;
    end while (s != 8'hF8 && n < 3000);
    chk({tag, " stop status"}, s, 8'hF8);
    rd(2'd1, c);
    chk({tag, " stop flag"}, 8'(c[3]), 8'h00);
    chk({tag, " stop lines"}, {6'd0, sclDrvLow, sdaDrvLow}, 8'h00);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got %0d cycles expected completion", WATCHDOG);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, v); chk("R1 status", v, 8'hF8);
    rd(2'd1, v); chk("R1 control", v, 8'h00);
    chk("R1 pins/irq", {5'd0, irq, sclDrvLow, sdaDrvLow}, 8'h00);

    // R4 exhaustive address sweep, both directions; R2 start; R7 stop
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        logic [7:0] e;
        bit hit;
        hit = (7'(a) == SLV);
        e = rw ? (hit ? 8'h40 : 8'h48) : (hit ? 8'h18 : 8'h20);
        doStart(8'h08, "R2 start");
        sendByte({7'(a), 1'(rw)}, e, "R4 address");
        if (hit && rw == 1) recvByte(1'b0, rdPattern(0), "R6 single read");
        doStop("R7");
      end
    end

    // R5 all transmit values, 0xFF NAKed by the slave
    doStart(8'h08, "R2 start");
    sendByte({SLV, 1'b0}, 8'h18, "R4 address write");
    for (int b = 0; b < 256; b++) begin
      sendByte(8'(b), (b == 255) ? 8'h30 : 8'h28, "R5 data");
      chk("R5 msb first", lastWritten, 8'(b));
    end
    doStop("R7");

    // R3 repeated start, R6 receive run
    doStart(8'h08, "R2 start");
    sendByte({SLV, 1'b0}, 8'h18, "R4 address write");
    sendByte(8'h11, 8'h28, "R5 data");
    doStart(8'h10, "R3 repeated start");
    sendByte({SLV, 1'b1}, 8'h40, "R4 address read");
    for (int k = 0; k < 16; k++) recvByte(k != 15, rdPattern(k), "R6 receive");
    doStop("R7");
    doStart(8'h08, "R7 tracking cleared");
    doStop("R7");

    // R8 interrupt enable and flag-set write
    wr(2'd1, 8'hE0);
    waitFlag("R8");
    chk("R8 irq high", 8'(irq), 8'h01);
    rd(2'd1, v); chk("R8 readback", v, 8'hC8);
    wr(2'd1, 8'hC8);
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk("R8 no step", v, 8'hC8);
    rd(2'd2, v); chk("R8 status kept", v, 8'h08);
    doStop("R7");
    chk("R8 irq low", 8'(irq), 8'h00);

    // R9 writes ignored while busy
    doStart(8'h08, "R2 start");
    sendByte({SLV, 1'b0}, 8'h18, "R4 address write");
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h77);
    wr(2'd1, 8'h60);
    waitFlag("R9");
    rd(2'd2, v); chk("R9 status", v, 8'h28);
    rd(2'd0, v); chk("R9 data kept", v, 8'h5A);
    chk("R9 sent byte", lastWritten, 8'h5A);
    doStop("R7");

    // R10 bus held low at START
    slvForce = 1'b1;
    doStart(8'h00, "R10 bus error");
    chk("R10 lines released", {6'd0, sclDrvLow, sdaDrvLow}, 8'h00);
    slvForce = 1'b0;
    repeat (4) @(negedge clk);

    // R11 soft reset mid-byte
    doStart(8'h08, "R2 start");
    sendByte({SLV, 1'b0}, 8'h18, "R4 address write");
    wr(2'd0, 8'h81);
    wr(2'd1, 8'h40);
    repeat (20) @(negedge clk);
    wr(2'd3, 8'h00);
    rd(2'd2, v); chk("R11 status", v, 8'hF8);
    rd(2'd1, v); chk("R11 flag", 8'(v[3]), 8'h00);
    repeat (4) @(negedge clk);
    chk("R11 lines released", {6'd0, sclDrvLow, sdaDrvLow}, 8'h00);
    doStart(8'h08, "R11 start after reset");
    doStop("R7");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule